// File: doc/BRIEF.md
# Asynchronous Byte-Wide Memory Controller

This block connects a synchronous request port to an external asynchronous byte-wide non-volatile RAM. The RAM has a 17-bit address, an 8-bit data bus split into output, drive enable and input, and three active-low strobes: chip enable, write enable and output enable. The host offers one transaction at a time with a valid/ready handshake. The transaction is either a write, which carries address and data, or a read, which carries an address. A read returns its byte with a single-cycle response pulse.

The controller runs each access as a strobe phase followed by a recovery phase. The length of every phase comes from nanosecond parameters and the clock period. Each length is the ceiling of the time divided by the period, and never less than one cycle. A read drops chip enable and output enable together and samples the bus once the slower of the address access time and the output-enable access time has passed. A write drops chip enable and write enable together and drives data for the whole pulse. Output enable stays high throughout a write, so the memory's output drivers stay off while the controller drives the bus. Recovery keeps chip enable high long enough to meet the minimum access spacing, the bus release time and the write recovery time.

Top module: `abm_ctrl`

## Requirements
- R1: While reset is asserted and directly after it is released, all three strobes are high (1), the data drive enable is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read drives chip enable and output enable low (0) with write enable high (1). The request address stays on `mem_addr` without change for every cycle that chip enable is low.
- R3: A read holds its strobes low for max(ceil(T_ACC_NS/CLK_NS), ceil(T_OE_ACC_NS/CLK_NS)) cycles, which is 5 cycles at the defaults. It captures `mem_dq_i` at the last edge of that phase. `rsp_valid` is high, with the captured byte on `rsp_rdata`, in the cycle that follows. If the handshake completes at edge k, that cycle lies between edges k+5 and k+6.
- R4: A write holds chip enable and write enable low together for max of ceil(T_WP_NS, T_DSU_NS, T_AWE_NS over CLK_NS) cycles, which is 3 cycles at the defaults. That pulse is at least 15 ns long. Output enable is high in every cycle of the write.
- R5: The data drive enable is 1 only while write enable is low and output enable is high. The write byte is on `mem_dq_o` from the first cycle of the pulse, at least 10 ns before the pulse ends.
- R6: The address is valid at least 18 ns before write enable rises. It then stays unchanged for at least T_WREC_NS (12 ns) after the rise.
- R7: Successive falling edges of chip enable are at least T_CYCLE_NS (35 ns) apart.
- R8: After chip enable rises, at least T_HZ_NS (15 ns) passes before the controller drives the data bus again.
- R9: `req_ready` is 0 whenever chip enable is low. Each completed handshake produces exactly one chip-enable access. A request that waits with `req_valid` high is taken once, and only when the controller becomes idle.
- R10: `rsp_valid` is never high for two cycles in a row. It pulses once for every read and never for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a transaction |
| req_ready | output | 1 | Controller is idle and takes the offer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read byte valid |
| rsp_rdata | output | 8 | Byte returned by a read |
| mem_addr | output | 17 | Address to the RAM |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Byte the controller drives on the data bus |
| mem_dq_oe | output | 1 | 1 = controller drives the data bus |
| mem_dq_i | input | 8 | Byte read back from the data bus |

## Verification
The bench models the RAM in time. The model returns the stored byte only after 35 ns of chip enable low and 15 ns of output enable low, and returns 0xEE before that. A controller that samples one cycle early therefore hands back a wrong byte instead of a late one. The model times every write pulse, data setup, address setup and address recovery in nanoseconds, and it also times the gap between chip-enable falls and the bus release before a write. A design that shortens any phase, lets output enable fall during a write, or moves the address too soon after a write breaks one of these measured windows. The test mixes write-then-read and read-then-write to the same address, uses both end addresses, reads a location never written, and keeps `req_valid` high across a busy controller, so a duplicated or lost access shows up as a count mismatch.

// File: rtl/abm_pkg.sv
`timescale 1ns/1ps
package abm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ACCESS  = 2'd1,
      ST_RECOVER = 2'd2
   } abm_state_e;

   // Phase length in clock cycles: ceiling of ns / period, never below one.
   function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
      int unsigned c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/abm_phase_cnt.sv
`timescale 1ns/1ps
module abm_phase_cnt #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (load)       cnt_q <= load_val;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/abm_seq.sv
`timescale 1ns/1ps
module abm_seq #(
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned C_RD   = 5,
   parameter int unsigned C_WP   = 3,
   parameter int unsigned C_RREC = 2,
   parameter int unsigned C_WREC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             cnt_zero,
   output logic             req_ready,
   output logic             fire,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             cap,
   output logic             ce_n,
   output logic             we_n,
   output logic             oe_n,
   output logic             dq_oe
);
   import abm_pkg::*;

   localparam logic [CNT_W-1:0] LV_RD   = CNT_W'(C_RD - 1);
   localparam logic [CNT_W-1:0] LV_WP   = CNT_W'(C_WP - 1);
   localparam logic [CNT_W-1:0] LV_RREC = CNT_W'(C_RREC - 1);
   localparam logic [CNT_W-1:0] LV_WREC = CNT_W'(C_WREC - 1);

   abm_state_e st_q;
   logic       is_wr_q;
   logic       end_acc;

   assign req_ready = (st_q == ST_IDLE);
   assign fire      = req_valid && req_ready;
   assign end_acc   = (st_q == ST_ACCESS) && cnt_zero;
   assign load      = fire || end_acc;
   assign cap       = end_acc && !is_wr_q;

   always_comb begin
      if (st_q == ST_IDLE) load_val = req_write ? LV_WP : LV_RD;
      else                 load_val = is_wr_q ? LV_WREC : LV_RREC;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         is_wr_q <= 1'b0;
         ce_n    <= 1'b1;
         we_n    <= 1'b1;
         oe_n    <= 1'b1;
         dq_oe   <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: if (fire) begin
               st_q    <= ST_ACCESS;
               is_wr_q <= req_write;
               ce_n    <= 1'b0;
               we_n    <= !req_write;
               oe_n    <= req_write;
               dq_oe   <= req_write;
            end
            ST_ACCESS: if (cnt_zero) begin
               st_q  <= ST_RECOVER;
               ce_n  <= 1'b1;
               we_n  <= 1'b1;
               oe_n  <= 1'b1;
               dq_oe <= 1'b0;
            end
            ST_RECOVER: if (cnt_zero) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/abm_datapath.sv
`timescale 1ns/1ps
module abm_datapath #(
   parameter int unsigned ADDR_W     = 17,
   parameter int unsigned DATA_W     = 8,
   parameter bit          HOLD_RDATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic              cap,
   input  logic [DATA_W-1:0] mem_dq_i,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_addr  <= '0;
         mem_dq_o  <= '0;
         rsp_valid <= 1'b0;
         rdata_q   <= '0;
      end else begin
         rsp_valid <= cap;
         if (fire) mem_addr <= req_addr;
         if (fire && req_write) mem_dq_o <= req_wdata;
         if (cap) rdata_q <= mem_dq_i;
      end
   end

   generate
      if (HOLD_RDATA) begin : g_hold
         assign rsp_rdata = rdata_q;
      end else begin : g_mask
         assign rsp_rdata = rdata_q & {DATA_W{rsp_valid}};
      end
   endgenerate
endmodule

// File: rtl/abm_ctrl.sv
`timescale 1ns/1ps
module abm_ctrl #(
   parameter int unsigned ADDR_W      = 17,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned CLK_NS      = 8,
   parameter int unsigned T_CYCLE_NS  = 35,
   parameter int unsigned T_ACC_NS    = 35,
   parameter int unsigned T_OE_ACC_NS = 15,
   parameter int unsigned T_WP_NS     = 15,
   parameter int unsigned T_DSU_NS    = 10,
   parameter int unsigned T_AWE_NS    = 18,
   parameter int unsigned T_WREC_NS   = 12,
   parameter int unsigned T_HZ_NS     = 15,
   parameter int unsigned T_HIGH_NS   = 2,
   parameter bit          HOLD_RDATA  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_o,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_i
);
   import abm_pkg::*;

   localparam int unsigned C_CYC  = ns2cyc(T_CYCLE_NS, CLK_NS);
   localparam int unsigned C_HI   = ns2cyc(T_HIGH_NS, CLK_NS);
   localparam int unsigned C_HZ   = ns2cyc(T_HZ_NS, CLK_NS);
   localparam int unsigned C_WRC  = ns2cyc(T_WREC_NS, CLK_NS);
   localparam int unsigned C_RD   = umax(ns2cyc(T_ACC_NS, CLK_NS), ns2cyc(T_OE_ACC_NS, CLK_NS));
   localparam int unsigned C_WP   = umax(ns2cyc(T_WP_NS, CLK_NS),
                                         umax(ns2cyc(T_DSU_NS, CLK_NS), ns2cyc(T_AWE_NS, CLK_NS)));
   localparam int unsigned C_RREC = umax(C_HI, umax(C_HZ, (C_CYC > C_RD) ? C_CYC - C_RD : 1));
   localparam int unsigned C_WREC = umax(C_HI, umax(C_WRC, (C_CYC > C_WP) ? C_CYC - C_WP : 1));
   localparam int unsigned C_MAX  = umax(umax(C_RD, C_WP), umax(C_RREC, C_WREC));
   localparam int unsigned CNT_W  = $clog2(C_MAX) + 1;

   initial begin
      assert (CLK_NS > 0) else $fatal(1, "abm_ctrl: CLK_NS must be positive");
      assert (ADDR_W > 0 && DATA_W > 0) else $fatal(1, "abm_ctrl: bus widths must be positive");
   end

   logic             fire, load, cnt_zero, cap;
   logic [CNT_W-1:0] load_val;

   abm_seq #(
      .CNT_W(CNT_W), .C_RD(C_RD), .C_WP(C_WP), .C_RREC(C_RREC), .C_WREC(C_WREC)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .cnt_zero(cnt_zero), .req_ready(req_ready), .fire(fire), .load(load),
      .load_val(load_val), .cap(cap), .ce_n(mem_ce_n), .we_n(mem_we_n),
      .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
   );

   abm_phase_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .zero(cnt_zero)
   );

   abm_datapath #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HOLD_RDATA(HOLD_RDATA)
   ) dp_i (
      .clk(clk), .rst_n(rst_n), .fire(fire), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .cap(cap), .mem_dq_i(mem_dq_i),
      .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata)
   );
endmodule

// File: rtl/abm_ctrl_chk.sv
`timescale 1ns/1ps
module abm_ctrl_chk #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned C_CYC  = 5,
   parameter int unsigned C_WP   = 3,
   parameter int unsigned C_WREC = 2,
   parameter int unsigned C_HZ   = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic              mem_ce_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dq_oe,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_dq_o
);
   logic        ce_q, we_q, dqoe_q;
   logic [15:0] gap, wlow, hi_run, wrec;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q   <= 1'b1;
         we_q   <= 1'b1;
         dqoe_q <= 1'b0;
         gap    <= 16'hFFFF;
         wlow   <= 16'd0;
         hi_run <= 16'hFFFF;
         wrec   <= 16'd0;
      end else begin
         ce_q   <= mem_ce_n;
         we_q   <= mem_we_n;
         dqoe_q <= mem_dq_oe;
         gap    <= (ce_q && !mem_ce_n) ? 16'd1 : ((gap == 16'hFFFF) ? gap : gap + 16'd1);
         wlow   <= !mem_we_n ? ((wlow == 16'hFFFF) ? wlow : wlow + 16'd1) : 16'd0;
         hi_run <= mem_ce_n ? ((hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1) : 16'd0;
         wrec   <= (!we_q && mem_we_n) ? 16'(C_WREC) : ((wrec != 16'd0) ? wrec - 16'd1 : 16'd0);
      end
   end

   AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_ce_n); // R9
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && !ce_q) |-> $stable(mem_addr)); // R2
   AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_ce_n)); // R4
   AST_WRITE_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!we_q && mem_we_n) |-> (wlow >= 16'(C_WP))); // R4
   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (mem_oe_n && !mem_we_n)); // R5
   AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && dqoe_q) |-> $stable(mem_dq_o)); // R5
   AST_WRITE_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
      (wrec != 16'd0) |-> $stable(mem_addr)); // R6
   AST_ACCESS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_q && !mem_ce_n) |-> (gap >= 16'(C_CYC))); // R7
   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && !dqoe_q) |-> (hi_run >= 16'(C_HZ))); // R8
   AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R10
endmodule

bind abm_ctrl abm_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .C_CYC(C_CYC), .C_WP(C_WP),
   .C_WREC(C_WRC), .C_HZ(C_HZ)
) chk_i (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
   .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
   .mem_dq_oe(mem_dq_oe), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o)
);

// File: tb/abm_ctrl_tb_top.sv
`timescale 1ns/1ps
module abm_ctrl_tb_top;
   localparam int CLK_NS  = 8;
   localparam int RD_CYC  = (35 + CLK_NS - 1) / CLK_NS;
   localparam int WP_CYC  = (18 + CLK_NS - 1) / CLK_NS;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [16:0] req_addr;
   logic [7:0]  req_wdata;
   logic        req_ready, rsp_valid;
   logic [7:0]  rsp_rdata;
   logic [16:0] mem_addr;
   logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [7:0]  mem_dq_o, mem_dq_i;

   always #4 clk = ~clk;

   abm_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
   );

   int          n_chk = 0, n_fail = 0, n_hs = 0, n_falls = 0;
   longint      cyc = 0;
   logic [7:0]  model_mem [int];
   logic [7:0]  ref_mem [int];
   logic [7:0]  exp_q [$];
   longint      when_q [$];
   logic [7:0]  mdl_dq;
   realtime     t_ce_fall = -100.0, t_ce_rise = -100.0, t_oe_fall = -100.0;
   realtime     t_we_fall = -100.0, t_we_rise = -100.0, t_dq_chg = -100.0, t_addr_chg = -100.0;
   bit          ce_seen = 0, we_seen = 0, wr_done = 0;

   assign mem_dq_i = mdl_dq;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) cyc++;

   // RAM model: data appears only after the access times have elapsed
   initial begin
      mdl_dq = 8'hEE;
      forever begin
         #0.5;
         if (mem_ce_n === 1'b0 && mem_oe_n === 1'b0 && mem_we_n === 1'b1 &&
             ($realtime - t_ce_fall) >= 35.0 && ($realtime - t_oe_fall) >= 15.0)
            mdl_dq = model_mem.exists(int'(mem_addr)) ? model_mem[int'(mem_addr)] : 8'h00;
         else
            mdl_dq = 8'hEE;
      end
   end

   always @(negedge mem_ce_n) begin
      if (ce_seen) check(($realtime - t_ce_fall) >= 35.0, "R7 chip-enable spacing ns",
                         longint'($realtime - t_ce_fall), 35);
      ce_seen   = 1;
      t_ce_fall = $realtime;
      n_falls++;
   end
   always @(posedge mem_ce_n) t_ce_rise = $realtime;
   always @(negedge mem_oe_n) t_oe_fall = $realtime;
   always @(negedge mem_we_n) begin we_seen = 1; t_we_fall = $realtime; end
   always @(mem_dq_o) t_dq_chg = $realtime;
   always @(mem_addr) begin
      if (wr_done) check(($realtime - t_we_rise) >= 12.0, "R6 address recovery ns",
                         longint'($realtime - t_we_rise), 12);
      wr_done    = 0;
      t_addr_chg = $realtime;
   end
   always @(posedge mem_we_n) if (we_seen) begin
      we_seen = 0;
      check(($realtime - t_we_fall) >= 15.0, "R4 write pulse ns", longint'($realtime - t_we_fall), 15);
      check(($realtime - t_dq_chg) >= 10.0, "R5 data setup ns", longint'($realtime - t_dq_chg), 10);
      check(($realtime - t_addr_chg) >= 18.0, "R6 address setup ns", longint'($realtime - t_addr_chg), 18);
      model_mem[int'(mem_addr)] = mem_dq_o;
      t_we_rise = $realtime;
      wr_done   = 1;
   end
   always @(posedge mem_dq_oe) check(($realtime - t_ce_rise) >= 15.0, "R8 bus turnaround ns",
                                     longint'($realtime - t_ce_rise), 15);

   // Monitor: strobe run lengths, bus ownership, scoreboard of read responses
   bit          prev_ce_low = 0, prev_rsp = 0, run_wr = 0;
   int          run = 0;
   logic [16:0] run_addr;
   always @(negedge clk) if (rst_n) begin
      if (!mem_ce_n) check(req_ready == 1'b0, "R9 ready low while busy", req_ready, 0);
      if (mem_dq_oe) check(mem_oe_n && !mem_we_n, "R5 single bus driver", {mem_oe_n, mem_we_n}, 2'b10);
      if (!mem_we_n) check(mem_oe_n == 1'b1, "R4 output enable high in write", mem_oe_n, 1);
      if (!mem_ce_n) begin
         if (!prev_ce_low) begin
            run = 1; run_wr = !mem_we_n; run_addr = mem_addr;
            if (!run_wr) check(!mem_oe_n && mem_we_n, "R2 read strobes", {mem_oe_n, mem_we_n}, 2'b01);
         end else begin
            run++;
            check(mem_addr == run_addr, "R2 address stable in access", mem_addr, run_addr);
         end
      end else if (prev_ce_low) begin
         if (run_wr) check(run == WP_CYC, "R4 write strobe cycles", run, WP_CYC);
         else        check(run == RD_CYC, "R3 read strobe cycles", run, RD_CYC);
      end
      prev_ce_low = !mem_ce_n;
      if (rsp_valid) begin
         if (prev_rsp) check(0, "R10 response longer than one cycle", 2, 1);
         if (exp_q.size() == 0) check(0, "R10 response without read", 1, 0);
         else begin
            logic [7:0] e;
            longint     w;
            e = exp_q.pop_front();
            w = when_q.pop_front();
            check(rsp_rdata == e, "R3 read data", rsp_rdata, e);
            check(cyc == w, "R3 response cycle", cyc, w);
         end
      end
      prev_rsp = rsp_valid;
   end

   // Driver: one transaction per handshake, expected reads pushed to the scoreboard
   task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      while (!req_ready) @(negedge clk);
      if (wr) ref_mem[int'(a)] = d;
      else begin
         exp_q.push_back(ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 8'h00);
         when_q.push_back(cyc + 1 + RD_CYC);
      end
      n_hs++;
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(0, "R9 watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      check({mem_ce_n, mem_we_n, mem_oe_n} == 3'b111, "R1 strobes high in reset",
            {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
      check(!mem_dq_oe && !rsp_valid && req_ready, "R1 bus idle in reset",
            {mem_dq_oe, rsp_valid, req_ready}, 3'b001);
      rst_n = 1'b1;
      @(negedge clk);
      check({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready} == 5'b11101, "R1 idle after reset",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, req_ready}, 5'b11101);

      issue(1, 17'h00000, 8'h5A);
      issue(1, 17'h1FFFF, 8'hA5);
      issue(1, 17'h0AAAA, 8'hFF);
      issue(0, 17'h00000, 8'h00);
      issue(0, 17'h1FFFF, 8'h00);
      issue(0, 17'h0AAAA, 8'h00);
      issue(0, 17'h00123, 8'h00);
      issue(0, 17'h0AAAA, 8'h00);
      issue(1, 17'h0AAAA, 8'h3C);
      issue(0, 17'h0AAAA, 8'h00);
      repeat (7) @(negedge clk);
      issue(0, 17'h1FFFF, 8'h00);
      for (int i = 0; i < 24; i++)
         issue((i % 3) != 2, 17'((i * 37) & 63), 8'((i * 29 + 7) & 255));
      repeat (20) @(negedge clk);
      check(exp_q.size() == 0, "R10 every read answered", exp_q.size(), 0);
      check(n_falls == n_hs, "R9 one access per handshake", n_falls, n_hs);
      finish_run();
   end
endmodule